// File: doc/BRIEF.md
# Sub-Word Access Bridge for a Dword-Only Register Bus

This bridge lets a requester issue reads and writes of one, two or four bytes at any byte address to a register bus that only accepts whole, aligned 32-bit accesses. For a read, the bridge fetches the dword that contains the addressed bytes. It shifts the wanted lanes down to bit 0 and zeroes everything above the requested width. A full dword write is passed through as one downstream write. A byte or halfword write becomes a read-modify-write: the bridge fetches the dword, replaces only the addressed lanes and writes the dword back.

The bridge rejects a request with an error flag and issues no downstream access when its size is not a legal width, or when its address is not a multiple of its size. Both sides use a valid/ready handshake. The bridge holds a single request at a time. Arbitration against other bus masters, and atomicity of the read-modify-write pair, are the concern of the surrounding system.

Top module: `sw_access_bridge`

## Requirements
- R1: Every downstream access carries the request address with bits [1:0] forced to zero, so it reaches the dword that holds the addressed bytes.
- R2: A legal read returns the fetched dword shifted right by 8 times the byte offset (address bits [1:0]). For a size of 1 or 2, all bits above bit 7 or bit 15 are zero. `req_size` is the byte count: 1, 2 or 4.
- R3: A legal 4-byte write is issued as exactly one downstream write carrying the request data, with no downstream read.
- R4: A legal 1- or 2-byte write is issued as one downstream read followed by one downstream write. The written dword equals the fetched dword with only the addressed byte lanes replaced by the low bytes of the request data.
- R5: A request with a legal size whose address is not a multiple of that size gets a response with `rsp_err` = 1 and causes no downstream access.
- R6: A request whose `req_size` is not 1, 2 or 4 (for example 0, 3, 5, 6 or 7) gets a response with `rsp_err` = 1 and causes no downstream access.
- R7: A rejected read returns 32'hFFFFFFFF. Any write response returns zero data. Every accepted legal request answers with `rsp_err` = 0.
- R8: `req_ready` is low from the cycle after a request is accepted until the response handshake completes, so at most one request is in flight.
- R9: While `rsp_valid` is high and `rsp_ready` is low, the response and its data and error flag stay unchanged.
- R10: While `bus_valid` is high and `bus_ready` is low, the downstream command (address, direction and write data) stays unchanged.
- R11: During reset, `req_ready` is high and both `bus_valid` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 3 | Access width in bytes (1, 2 or 4 legal) |
| req_wdata | input | DATA_W | Write data, right-aligned |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_rdata | output | DATA_W | Read data, right-aligned |
| rsp_err | output | 1 | Request was rejected |
| bus_valid | output | 1 | Downstream command present |
| bus_ready | input | 1 | Downstream completes the command this cycle |
| bus_write | output | 1 | Downstream direction, 1 = write |
| bus_addr | output | ADDR_W | Dword-aligned downstream address |
| bus_wdata | output | DATA_W | Downstream write dword |
| bus_rdata | input | DATA_W | Downstream read dword, valid with bus_ready |

## Verification
The bench covers byte reads and writes at all four lanes, halfword accesses at offsets 0 and 2, and halfword and word accesses at every misaligned offset. It also covers every illegal size code. A design with wrong lane arithmetic would return neighbouring bytes or leave stray upper bits. One that ignored the fetched dword would clobber untouched lanes. One that let a rejected request reach the bus would show up as an extra downstream access in the bench's per-request transaction counts. A downstream model with random stalls, together with a random hold-off on the response side, would expose a bridge that drops a command or response while it is stalled.

// File: rtl/sw_bridge_pkg.sv
// Shared types for the sub-word access bridge.
// Assumes: nothing beyond standard SystemVerilog.
package sw_bridge_pkg;

    // Controller phases: wait, fetch dword, store dword, hold response.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_STORE = 2'd2,
        ST_REPLY = 2'd3
    } sw_state_e;

endpackage

// File: rtl/sw_req_decode.sv
// Request legality and lane decode.
// What it does: classifies an incoming size/offset pair as illegal-size,
// misaligned or legal, flags a full-width access, and produces the byte
// lanes the access touches.
// Assumes: the size is a byte count and the bus width is a power of two bytes.
module sw_req_decode #(
    parameter int BYTES  = 4,
    localparam int OFF_W  = $clog2(BYTES),
    localparam int SIZE_W = OFF_W + 1
) (
    input  logic [OFF_W-1:0]  addr_lo,
    input  logic [SIZE_W-1:0] size,
    output logic              size_bad,
    output logic              misalign,
    output logic              full,
    output logic [BYTES-1:0]  lane_en
);

    logic [SIZE_W-1:0] size_m1;
    logic [SIZE_W:0]   lane_end;

    // Size legality: nonzero, a power of two, not wider than the bus.
    always_comb begin
        size_m1  = size - SIZE_W'(1);
        size_bad = (size == '0) || ((size & size_m1) != '0) ||
                   (32'(size) > BYTES);
        misalign = !size_bad && ((addr_lo & size_m1[OFF_W-1:0]) != '0);
        full     = (32'(size) == BYTES);
        lane_end = (SIZE_W+1)'(addr_lo) + (SIZE_W+1)'(size);
    end

    // One enable per byte lane covered by [offset, offset+size).
    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        assign lane_en[i] = (32'(addr_lo) <= i) && (32'(lane_end) > i);
    end

endmodule

// File: rtl/sw_lane_unit.sv
// Byte-lane datapath.
// What it does: extracts a right-aligned, zero-extended value from a fetched
// dword, and merges new bytes into a fetched dword at the addressed lanes.
// Assumes: offset/size/lanes come from registers and describe a legal access.
module sw_lane_unit #(
    parameter int DATA_W = 32,
    localparam int BYTES  = DATA_W / 8,
    localparam int OFF_W  = $clog2(BYTES),
    localparam int SIZE_W = OFF_W + 1
) (
    input  logic [DATA_W-1:0] fetched,
    input  logic [DATA_W-1:0] new_data,
    input  logic [OFF_W-1:0]  offset,
    input  logic [SIZE_W-1:0] size,
    input  logic [BYTES-1:0]  lane_en,
    output logic [DATA_W-1:0] read_out,
    output logic [DATA_W-1:0] merged
);

    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] placed;

    // Move fetched lanes down and new lanes up by the byte offset.
    always_comb begin
        shifted = fetched  >> {offset, 3'b000};
        placed  = new_data << {offset, 3'b000};
    end

    // Per lane: keep low lanes of the read, pick new or old byte for merge.
    for (genvar i = 0; i < BYTES; i++) begin : g_byte
        assign read_out[8*i +: 8] = (32'(size) > i) ? shifted[8*i +: 8] : 8'h00;
        assign merged[8*i +: 8]   = lane_en[i] ? placed[8*i +: 8] : fetched[8*i +: 8];
    end

endmodule

// File: rtl/sw_bridge_ctrl.sv
// Sequencing controller for the sub-word bridge.
// What it does: takes one request, then runs fetch and/or store on the dword
// bus and holds the response until it is taken.
// Assumes: downstream read data is valid in the cycle bus_ready is high;
// decode and lane results are supplied by the sibling units.
module sw_bridge_ctrl
    import sw_bridge_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int BYTES  = DATA_W / 8,
    localparam int OFF_W  = $clog2(BYTES),
    localparam int SIZE_W = OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              dec_reject,
    input  logic              dec_full,
    input  logic [BYTES-1:0]  dec_lanes,
    input  logic [DATA_W-1:0] lane_read,
    input  logic [DATA_W-1:0] lane_merged,
    output logic [OFF_W-1:0]  q_offset,
    output logic [SIZE_W-1:0] q_size,
    output logic [BYTES-1:0]  q_lanes,
    output logic [DATA_W-1:0] q_wdata,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              bus_valid,
    input  logic              bus_ready,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata
);

    sw_state_e         state;
    logic              write_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] store_q;
    logic [DATA_W-1:0] rdata_q;
    logic              err_q;
    logic              take;

    assign take = req_valid && (state == ST_IDLE);

    // Phase register: idle -> fetch/store/reply -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (dec_reject)                 state <= ST_REPLY;
                        else if (req_write && dec_full) state <= ST_STORE;
                        else                            state <= ST_FETCH;
                    end
                end
                ST_FETCH: if (bus_ready) state <= write_q ? ST_STORE : ST_REPLY;
                ST_STORE: if (bus_ready) state <= ST_REPLY;
                ST_REPLY: if (rsp_ready) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Capture request fields on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            write_q  <= 1'b0;
            addr_q   <= '0;
            q_offset <= '0;
            q_size   <= '0;
            q_lanes  <= '0;
            q_wdata  <= '0;
        end else if (take) begin
            write_q  <= req_write;
            addr_q   <= {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            q_offset <= req_addr[OFF_W-1:0];
            q_size   <= req_size;
            q_lanes  <= dec_lanes;
            q_wdata  <= req_wdata;
        end
    end

    // Dword to store: request data for full writes, merge result otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= '0;
        end else if (take && req_write && dec_full) begin
            store_q <= req_wdata;
        end else if (state == ST_FETCH && bus_ready && write_q) begin
            store_q <= lane_merged;
        end
    end

    // Response contents: error fill, extracted read, or write acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else if (take && dec_reject) begin
            rdata_q <= req_write ? '0 : '1;
            err_q   <= 1'b1;
        end else if (state == ST_FETCH && bus_ready && !write_q) begin
            rdata_q <= lane_read;
            err_q   <= 1'b0;
        end else if (state == ST_STORE && bus_ready) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end
    end

    // Outputs derived from the phase.
    always_comb begin
        req_ready = (state == ST_IDLE);
        bus_valid = (state == ST_FETCH) || (state == ST_STORE);
        bus_write = (state == ST_STORE);
        bus_addr  = addr_q;
        bus_wdata = store_q;
        rsp_valid = (state == ST_REPLY);
        rsp_rdata = rdata_q;
        rsp_err   = err_q;
    end

endmodule

// File: rtl/sw_access_bridge.sv
// Top of the sub-word access bridge.
// What it does: joins the decode, lane datapath and controller so that
// 1/2/4-byte requests become aligned dword accesses.
// Assumes: a single requester and exclusive use of the dword bus.
module sw_access_bridge #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int BYTES  = DATA_W / 8,
    localparam int OFF_W  = $clog2(BYTES),
    localparam int SIZE_W = OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              bus_valid,
    input  logic              bus_ready,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata
);

    logic              size_bad, misalign, dec_full;
    logic [BYTES-1:0]  dec_lanes;
    logic [OFF_W-1:0]  q_offset;
    logic [SIZE_W-1:0] q_size;
    logic [BYTES-1:0]  q_lanes;
    logic [DATA_W-1:0] q_wdata;
    logic [DATA_W-1:0] lane_read, lane_merged;

    sw_req_decode #(.BYTES(BYTES)) u_dec (
        .addr_lo  (req_addr[OFF_W-1:0]),
        .size     (req_size),
        .size_bad (size_bad),
        .misalign (misalign),
        .full     (dec_full),
        .lane_en  (dec_lanes)
    );

    sw_lane_unit #(.DATA_W(DATA_W)) u_lane (
        .fetched  (bus_rdata),
        .new_data (q_wdata),
        .offset   (q_offset),
        .size     (q_size),
        .lane_en  (q_lanes),
        .read_out (lane_read),
        .merged   (lane_merged)
    );

    sw_bridge_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_size    (req_size),
        .req_wdata   (req_wdata),
        .dec_reject  (size_bad || misalign),
        .dec_full    (dec_full),
        .dec_lanes   (dec_lanes),
        .lane_read   (lane_read),
        .lane_merged (lane_merged),
        .q_offset    (q_offset),
        .q_size      (q_size),
        .q_lanes     (q_lanes),
        .q_wdata     (q_wdata),
        .rsp_valid   (rsp_valid),
        .rsp_ready   (rsp_ready),
        .rsp_rdata   (rsp_rdata),
        .rsp_err     (rsp_err),
        .bus_valid   (bus_valid),
        .bus_ready   (bus_ready),
        .bus_write   (bus_write),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata)
    );

endmodule

// File: rtl/sw_access_bridge_chk.sv
// Protocol checker for the sub-word bridge, bound to the top module.
// What it does: checks alignment, single-outstanding behaviour, rejection
// handling and handshake stability at the block's ports.
// Assumes: synchronous active-low reset on rst_n.
module sw_access_bridge_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int BYTES  = DATA_W / 8,
    localparam int OFF_W  = $clog2(BYTES),
    localparam int SIZE_W = OFF_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [SIZE_W-1:0] req_size,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              rsp_err,
    input logic              bus_valid,
    input logic              bus_ready,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata
);

    logic [SIZE_W-1:0] sz_m1;
    logic              illegal;
    logic              accept;

    always_comb begin
        sz_m1   = req_size - SIZE_W'(1);
        illegal = (req_size == '0) || ((req_size & sz_m1) != '0) ||
                  (32'(req_size) > BYTES) ||
                  ((req_addr[OFF_W-1:0] & sz_m1[OFF_W-1:0]) != '0);
        accept  = req_valid && req_ready;
    end

    // R1
    bus_addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_addr[OFF_W-1:0] == '0));

    // R3
    full_write_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !illegal && req_write && 32'(req_size) == BYTES) |=> (bus_valid && bus_write));

    // R4
    partial_write_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !illegal && req_write && 32'(req_size) != BYTES) |=> (bus_valid && !bus_write));

    // R5
    reject_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && illegal) |=> (rsp_valid && rsp_err && !bus_valid));

    // R7
    write_ack_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_ready) |=> (rsp_valid && !rsp_err && rsp_rdata == '0));

    // R8
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid || rsp_valid) |-> !req_ready);

    // R9
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

    // R10
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=>
            (bus_valid && $stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata)));

endmodule

bind sw_access_bridge sw_access_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err),
    .bus_valid (bus_valid),
    .bus_ready (bus_ready),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
);

// File: tb/sim_sw_access_bridge.sv
// Self-checking bench: directed corners plus seeded random requests against
// a stalling 16-dword downstream memory model.
module sim_sw_access_bridge;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic        bus_valid;
    logic        bus_ready = 1'b0;
    logic        bus_write;
    logic [31:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;

    logic [31:0] mem [16];
    logic [31:0] shadow [16];
    int n_rd = 0, n_wr = 0;
    int checks = 0, fails = 0, cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sw_access_bridge u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] init_word(input int i);
        return 32'hA55A_0000 ^ (32'(i) * 32'h0103_0507);
    endfunction

    // Downstream memory model and transaction counters.
    assign bus_rdata = mem[bus_addr[5:2]];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] <= init_word(i);
        end else if (bus_valid && bus_ready) begin
            if (bus_write) begin
                mem[bus_addr[5:2]] <= bus_wdata;
                n_wr <= n_wr + 1;
            end else begin
                n_rd <= n_rd + 1;
            end
        end
    end

    // Random downstream stalls.
    always @(negedge clk) bus_ready <= ($urandom % 3) != 0;

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            fails = fails + 1;
            $display("FAIL watchdog: cycles %0d expected below %0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] f_read(input logic [31:0] w, input int off, input int sz);
        logic [31:0] r = '0;
        for (int b = 0; b < sz; b++) r[8*b +: 8] = w[8*(off+b) +: 8];
        return r;
    endfunction

    function automatic logic [31:0] f_merge(input logic [31:0] w, input logic [31:0] nw,
                                            input int off, input int sz);
        logic [31:0] r = w;
        for (int b = 0; b < sz; b++) r[8*(off+b) +: 8] = nw[8*b +: 8];
        return r;
    endfunction

    // One request end to end; called and returns at a negedge.
    task automatic do_req(input bit wr, input logic [31:0] addr, input logic [2:0] sz,
                          input logic [31:0] wd);
        int off = int'(addr[1:0]);
        int idx = int'(addr[5:2]);
        int isz = int'(sz);
        bit size_ok = (isz == 1) || (isz == 2) || (isz == 4);
        bit legal = size_ok && ((off % (size_ok ? isz : 1)) == 0);
        string tag;
        logic [31:0] exp_d;
        int exp_rd, exp_wr, rd0, wr0, wait_n;
        bit acc, busy_bad, hold_ok, mem_ok;
        logic [31:0] first_d;
        logic first_e;

        if (!size_ok)      tag = "R6";
        else if (!legal)   tag = wr ? "R5" : "R7";
        else if (!wr)      tag = "R2";
        else if (isz == 4) tag = "R3";
        else               tag = "R4";

        exp_rd = 0; exp_wr = 0;
        if (!legal) exp_d = wr ? 32'h0 : 32'hFFFF_FFFF;
        else if (!wr) begin exp_d = f_read(shadow[idx], off, isz); exp_rd = 1; end
        else begin
            exp_d = 32'h0; exp_wr = 1;
            if (isz != 4) exp_rd = 1;
            shadow[idx] = (isz == 4) ? wd : f_merge(shadow[idx], wd, off, isz);
        end

        rd0 = n_rd; wr0 = n_wr;
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_size = sz; req_wdata = wd;
        forever begin
            acc = req_ready;
            @(posedge clk); @(negedge clk);
            if (acc) break;
        end
        req_valid = 1'b0;

        busy_bad = 1'b0;
        while (!rsp_valid) begin
            if (req_ready) busy_bad = 1'b1;
            @(negedge clk);
        end
        first_d = rsp_rdata; first_e = rsp_err;
        hold_ok = 1'b1;
        wait_n = $urandom % 3;
        repeat (wait_n) begin
            @(negedge clk);
            if (req_ready) busy_bad = 1'b1;
            if (!rsp_valid || rsp_rdata != first_d || rsp_err != first_e) hold_ok = 1'b0;
        end
        // R9 response held while stalled
        check(hold_ok, "R9", rsp_rdata, first_d);
        check(rsp_rdata == exp_d, tag, rsp_rdata, exp_d);
        // R7 error flag
        check(rsp_err == !legal, {tag, "/R7 err"}, 32'(rsp_err), 32'(!legal));
        rsp_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        rsp_ready = 1'b0;
        // R8 no second acceptance while busy
        check(!busy_bad, "R8", 32'(busy_bad), 32'h0);
        check((n_rd - rd0) == exp_rd, {tag, " reads"}, 32'(n_rd - rd0), 32'(exp_rd));
        check((n_wr - wr0) == exp_wr, {tag, " writes"}, 32'(n_wr - wr0), 32'(exp_wr));
        // R1 / R4: only the addressed dword and lanes changed
        mem_ok = 1'b1;
        for (int i = 0; i < 16; i++) if (mem[i] !== shadow[i]) mem_ok = 1'b0;
        check(mem_ok, "R1/R4 memory", mem[idx], shadow[idx]);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) shadow[i] = init_word(i);
        repeat (3) @(negedge clk);
        // R11 reset state
        check(req_ready === 1'b1, "R11 req_ready", 32'(req_ready), 32'h1);
        check(bus_valid === 1'b0, "R11 bus_valid", 32'(bus_valid), 32'h0);
        check(rsp_valid === 1'b0, "R11 rsp_valid", 32'(rsp_valid), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed: reads of every width at every offset (legal and not).
        for (int o = 0; o < 4; o++) begin
            do_req(1'b0, 32'h14 + 32'(o), 3'd1, '0);
            do_req(1'b0, 32'h14 + 32'(o), 3'd2, '0);
            do_req(1'b0, 32'h14 + 32'(o), 3'd4, '0);
        end
        // Directed: byte writes to each lane, halfword writes, full write.
        for (int o = 0; o < 4; o++) do_req(1'b1, 32'h20 + 32'(o), 3'd1, 32'hFFFF_FF00 | 32'(o + 8'h60));
        do_req(1'b1, 32'h24, 3'd2, 32'hDEAD_BEEF);
        do_req(1'b1, 32'h26, 3'd2, 32'h1234_CAFE);
        do_req(1'b1, 32'h25, 3'd2, 32'h0000_7777);
        do_req(1'b1, 32'h2A, 3'd4, 32'h5555_5555);
        do_req(1'b1, 32'h28, 3'd4, 32'h0BAD_F00D);
        // Directed: illegal sizes for reads and writes.
        for (int s = 0; s < 8; s++) if (s != 1 && s != 2 && s != 4) begin
            do_req(1'b0, 32'h30, 3'(s), '0);
            do_req(1'b1, 32'h30, 3'(s), 32'hFFFF_FFFF);
        end

        // Random mix.
        for (int n = 0; n < 400; n++) begin
            int pick = $urandom % 10;
            logic [2:0] sz;
            if (pick < 3)      sz = 3'd1;
            else if (pick < 6) sz = 3'd2;
            else if (pick < 9) sz = 3'd4;
            else               sz = 3'($urandom % 8);
            do_req(1'($urandom % 2), 32'($urandom % 64), sz, $urandom);
        end
        finish_run();
    end

endmodule